// File: doc/BRIEF.md
# Reference Frequency Estimator Counter

This block helps a clock-synthesis loop lock quickly when the frequency of its input reference is unknown. After a start pulse it times a window that spans K periods of the prescaled reference, measuring the window in system-clock periods. The system clock is the converter sample clock, so the measurement resolution is one system-clock period. From the measured period count, the programmed K and the feedback divider S, it then derives the 48-bit synthesizer tuning word that makes the divided synthesizer output match the prescaled reference. For a measured count C, this word is floor(S·K·2^48 / C).

The reference arrives as a one-cycle strobe that is already synchronized to the system clock. The period counter is 17 bits wide, so a window can span at most 2^17 − 1 system clocks. A longer window is reported as an overflow and never wraps. The tuning word comes from a restoring divider that produces one quotient bit per clock. Control is plain. The caller raises `start_i` for one cycle while the block is idle. `busy_o` covers the job and `done_o` pulses once when it ends. The results are level outputs that hold until the next accepted start, and there is no ready input and no back-pressure. A caller that misses the `done_o` pulse can read the held results at any later time.

Top module: `ref_freq_estimator`

## Requirements
- R1: While reset is held, and after it is released, `busy_o`, `done_o` and `ovf_o` are 0, and `count_o` and `tw_o` are all zeros.
- R2: A start pulse with a nonzero K, seen while `busy_o` is 0, makes `busy_o` 1 from the next cycle. `busy_o` stays 1 until the job ends. In the cycle where it falls, `done_o` is 1 for exactly one cycle.
- R3: K and S are captured when a start is accepted. The first reference strobe sampled after the accepting clock opens the window. Counting the strobes that follow it, the K-th one closes the window. `count_o` is the number of system clocks between the opening strobe and the closing strobe, and `ovf_o` is 0.
- R4: If the window would reach 2^17 system clocks, the block stops. It sets `count_o` to 2^17 − 1 and `ovf_o` to 1, pulses `done_o`, and leaves `tw_o` unchanged.
- R5: After a window without overflow, where S·K < `count_o`, `tw_o` equals floor(S·K·2^48 / `count_o`).
- R6: After a window without overflow, where S·K ≥ `count_o`, `tw_o` saturates to all ones (2^48 − 1).
- R7: A start with K = 0, seen while idle, is rejected. In the next cycle `done_o` is 1 and `ovf_o` is 1. `busy_o` stays 0, and `count_o` and `tw_o` keep their values.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored, including any new K and S values presented with it.
- R9: `count_o`, `tw_o` and `ovf_o` hold their values while the block is idle. An accepted start clears `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (sample) clock, the measurement time base |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a measurement |
| ref_edge_i | input | 1 | Synchronized one-cycle strobe per prescaled reference period |
| k_i | input | 16 | Number of reference periods in the window |
| s_i | input | 16 | Feedback divider modulus used in the tuning word |
| busy_o | output | 1 | High while a job is in progress |
| done_o | output | 1 | One-cycle pulse when a job or a rejection ends |
| ovf_o | output | 1 | Window overflow or K = 0 rejection |
| count_o | output | 17 | Measured system clocks across the window |
| tw_o | output | 48 | Computed tuning word |

## Verification
Windows with fixed strobe gaps give an exact count that can be checked by hand. Random gaps show that the count is a sum of uneven intervals and is not K times a single period. Back-to-back strobes (gap 1) exercise the tightest edge detection and the saturated tuning word. Choosing S·K equal to the count, and one below it, separates the saturation rule from the division. A window of exactly 2^17 clocks shows that overflow is detected at the boundary and is not a wrap. A start with K = 0, and a start that arrives mid-window with a different K, show that the rejection path and the start-ignore path each leave the results as the requirements state.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  typedef enum logic [1:0] {
    TOP_IDLE = 2'd0,
    TOP_MEAS = 2'd1,
    TOP_DIV  = 2'd2
  } top_state_e;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_ARM  = 2'd1,
    WIN_RUN  = 2'd2
  } win_state_e;

endpackage

// File: rtl/rfe_window.sv
module rfe_window
  import rfe_pkg::*;
#(
  parameter int KW = 16,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [KW-1:0] k_i,
  input  logic          edge_i,
  output logic          fin_o,
  output logic          ovf_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] CMAX = '1;

  win_state_e    state;
  logic [CW-1:0] run_cnt;
  logic [KW-1:0] seen;
  logic [KW-1:0] last_idx;

  assign last_idx = k_i - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= WIN_IDLE;
      run_cnt <= '0;
      seen    <= '0;
      fin_o   <= 1'b0;
      ovf_o   <= 1'b0;
      count_o <= '0;
    end else begin
      fin_o <= 1'b0;
      ovf_o <= 1'b0;
      case (state)
        WIN_IDLE: if (arm_i) state <= WIN_ARM;
        WIN_ARM: begin
          if (edge_i) begin
            run_cnt <= '0;
            seen    <= '0;
            state   <= WIN_RUN;
          end
        end
        WIN_RUN: begin
          if (run_cnt == CMAX) begin
            // next clock would need an 18th bit: report, never wrap
            fin_o   <= 1'b1;
            ovf_o   <= 1'b1;
            count_o <= CMAX;
            state   <= WIN_IDLE;
          end else begin
            run_cnt <= run_cnt + 1'b1;
            if (edge_i) begin
              if (seen == last_idx) begin
                fin_o   <= 1'b1;
                count_o <= run_cnt + 1'b1;
                state   <= WIN_IDLE;
              end else begin
                seen <= seen + 1'b1;
              end
            end
          end
        end
        default: state <= WIN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rfe_divider.sv
module rfe_divider #(
  parameter int NW = 32,
  parameter int DW = 17,
  parameter int QW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);

  localparam int IW = $clog2(QW + 1);

  logic          run;
  logic [DW-1:0] den_r;
  logic [DW-1:0] rem;
  logic [IW-1:0] step;
  logic [DW:0]   shifted;
  logic [DW:0]   diff;
  logic          take;
  logic [DW-1:0] rem_nxt;

  always_comb begin
    shifted = {rem, 1'b0};
    diff    = shifted - {1'b0, den_r};
    take    = shifted >= {1'b0, den_r};
    rem_nxt = take ? diff[DW-1:0] : shifted[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      den_r  <= '0;
      rem    <= '0;
      step   <= '0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        den_r <= den_i;
        if (num_i >= {{(NW-DW){1'b0}}, den_i}) begin
          // ratio of one or more cannot fit the word: saturate
          quo_o  <= '1;
          done_o <= 1'b1;
        end else begin
          rem   <= num_i[DW-1:0];
          quo_o <= '0;
          step  <= '0;
          run   <= 1'b1;
        end
      end else if (run) begin
        rem   <= rem_nxt;
        quo_o <= {quo_o[QW-2:0], take};
        step  <= step + 1'b1;
        if (step == IW'(QW - 1)) begin
          run    <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ref_freq_estimator.sv
module ref_freq_estimator
  import rfe_pkg::*;
#(
  parameter int KW = 16,
  parameter int SW = 16,
  parameter int CW = 17,
  parameter int TW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ref_edge_i,
  input  logic [KW-1:0] k_i,
  input  logic [SW-1:0] s_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ovf_o,
  output logic [CW-1:0] count_o,
  output logic [TW-1:0] tw_o
);

  localparam int PW = KW + SW;

  top_state_e    state;
  logic [KW-1:0] k_r;
  logic [SW-1:0] s_r;
  logic [PW-1:0] prod;
  logic          accept, reject;
  logic          win_fin, win_ovf;
  logic [CW-1:0] win_count;
  logic          div_start, div_done;
  logic [TW-1:0] div_quo;

  assign accept    = (state == TOP_IDLE) && start_i && (k_i != '0);
  assign reject    = (state == TOP_IDLE) && start_i && (k_i == '0);
  assign prod      = PW'(s_r) * PW'(k_r);
  assign div_start = (state == TOP_MEAS) && win_fin && !win_ovf;
  assign busy_o    = (state != TOP_IDLE);

  rfe_window #(.KW(KW), .CW(CW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (accept),
    .k_i     (k_r),
    .edge_i  (ref_edge_i),
    .fin_o   (win_fin),
    .ovf_o   (win_ovf),
    .count_o (win_count)
  );

  rfe_divider #(.NW(PW), .DW(CW), .QW(TW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .num_i   (prod),
    .den_i   (win_count),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TOP_IDLE;
      k_r     <= '0;
      s_r     <= '0;
      done_o  <= 1'b0;
      ovf_o   <= 1'b0;
      count_o <= '0;
      tw_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        TOP_IDLE: begin
          if (accept) begin
            k_r   <= k_i;
            s_r   <= s_i;
            ovf_o <= 1'b0;
            state <= TOP_MEAS;
          end else if (reject) begin
            done_o <= 1'b1;
            ovf_o  <= 1'b1;
          end
        end
        TOP_MEAS: begin
          if (win_fin) begin
            count_o <= win_count;
            if (win_ovf) begin
              ovf_o  <= 1'b1;
              done_o <= 1'b1;
              state  <= TOP_IDLE;
            end else begin
              state <= TOP_DIV;
            end
          end
        end
        TOP_DIV: begin
          if (div_done) begin
            tw_o   <= div_quo;
            done_o <= 1'b1;
            state  <= TOP_IDLE;
          end
        end
        default: state <= TOP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int KW = 16,
  parameter int CW = 17,
  parameter int TW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [KW-1:0] k_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ovf_o,
  input logic [CW-1:0] count_o,
  input logic [TW-1:0] tw_o
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o)); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && k_i != '0) |=> busy_o); // R2
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ovf_o) |-> (count_o != '0)); // R3
  AST_OVF_KEEPS_TW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovf_o) |-> $stable(tw_o)); // R4
  AST_KZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && k_i == '0) |=> (done_o && ovf_o && !busy_o)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> ($stable(count_o) && $stable(tw_o))); // R9

endmodule

bind ref_freq_estimator rfe_checker #(.KW(KW), .CW(CW), .TW(TW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .k_i     (k_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ovf_o   (ovf_o),
  .count_o (count_o),
  .tw_o    (tw_o)
);

// File: tb/ref_freq_estimator_test.sv
module ref_freq_estimator_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ref_edge_i = 1'b0;
  logic [15:0] k_i = '0;
  logic [15:0] s_i = '0;
  logic        busy_o, done_o, ovf_o;
  logic [16:0] count_o;
  logic [47:0] tw_o;

  int checks = 0;
  int errors = 0;
  int ndone = 0;
  int done_busy_err = 0;
  int done_long_err = 0;
  logic done_prev = 1'b0;
  logic [47:0] tw_model = '0;
  logic [16:0] cnt_model = '0;

  always #4 clk = ~clk;

  ref_freq_estimator uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_edge_i(ref_edge_i),
    .k_i(k_i), .s_i(s_i), .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o),
    .count_o(count_o), .tw_o(tw_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        ndone++;
        if (busy_o) done_busy_err++;
        if (done_prev) done_long_err++;
      end
      done_prev = done_o;
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_tw(input longint unsigned sk,
                                         input longint unsigned cnt);
    logic [79:0] num;
    if (sk >= cnt) return '1;
    num = 80'(sk) << 48;
    return 48'(num / 80'(cnt));
  endfunction

  // gaps drawn from [glo, ghi]; poke issues a start mid-window (R8)
  task automatic run_case(input int unsigned k, input int unsigned s,
                          input int unsigned glo, input int unsigned ghi,
                          input bit poke, input string req);
    longint unsigned sum = 0;
    int d0 = ndone;
    bit ovf_exp;
    int wait_cnt = 0;
    start_i = 1'b1; k_i = 16'(k); s_i = 16'(s);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after start", 64'(busy_o), 64'd1);
    ref_edge_i = 1'b1;             // opening strobe
    @(negedge clk);
    for (int i = 1; i <= int'(k); i++) begin
      int unsigned g = glo + ($urandom % (ghi - glo + 1));
      sum += g;
      for (int j = 1; j < int'(g); j++) begin
        ref_edge_i = 1'b0;
        if (poke && i == 1 && j == 1) begin
          start_i = 1'b1; k_i = 16'(k + 5); s_i = 16'(s + 3);
        end else begin
          start_i = 1'b0;
        end
        @(negedge clk);
      end
      start_i = 1'b0;
      ref_edge_i = 1'b1;
      @(negedge clk);
    end
    ref_edge_i = 1'b0;
    while (ndone == d0 && wait_cnt < 200) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk(ndone == d0 + 1, req, "one done per job", 64'(ndone - d0), 64'd1);
    ovf_exp = (sum >= 64'd131072);
    if (ovf_exp) begin
      chk(ovf_o == 1'b1, "R4", "overflow flag", 64'(ovf_o), 64'd1);
      chk(count_o == 17'h1FFFF, "R4", "saturated count", 64'(count_o), 64'h1FFFF);
      chk(tw_o == tw_model, "R4", "tuning word kept", 64'(tw_o), 64'(tw_model));
      cnt_model = 17'h1FFFF;
    end else begin
      chk(ovf_o == 1'b0, "R3", "no overflow", 64'(ovf_o), 64'd0);
      chk(count_o == 17'(sum), req, "window count", 64'(count_o), 64'(sum));
      tw_model = exp_tw(64'(s) * 64'(k), sum);
      cnt_model = 17'(sum);
      chk(tw_o == tw_model, (64'(s) * 64'(k) >= sum) ? "R6" : "R5",
          "tuning word", 64'(tw_o), 64'(tw_model));
    end
    repeat (3) @(negedge clk);
    chk(count_o == cnt_model && tw_o == tw_model, "R9", "results held idle",
        64'(count_o), 64'(cnt_model));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && ovf_o == 0, "R1", "flags in reset",
        64'({busy_o, done_o, ovf_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_o == 0 && tw_o == 0, "R1", "results after reset", 64'(count_o), 64'd0);

    run_case(4, 7, 10, 10, 1'b0, "R3");        // count 40, tw 28/40
    run_case(8, 3, 1, 1, 1'b0, "R3");          // back-to-back strobes, saturates
    run_case(1, 1, 5, 5, 1'b0, "R3");          // 2^48/5
    run_case(1, 8, 9, 9, 1'b0, "R5");          // S*K = count-1
    run_case(1, 9, 9, 9, 1'b0, "R6");          // S*K = count
    run_case(6, 0, 3, 12, 1'b0, "R5");         // S = 0
    run_case(5, 2, 20, 40, 1'b1, "R8");        // mid-window start ignored
    for (int n = 0; n < 10; n++) begin
      int unsigned kk = 1 + ($urandom % 24);
      int unsigned ss = (n % 2 == 0) ? ($urandom % 8) : ($urandom % 65536);
      run_case(kk, ss, 2, 60, 1'b0, "R3");
    end

    // R7: K = 0 rejected, results kept
    start_i = 1'b1; k_i = '0; s_i = 16'd77;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1 && ovf_o == 1 && busy_o == 0, "R7", "K=0 rejected",
        64'({done_o, ovf_o, busy_o}), 64'b110);
    chk(count_o == cnt_model && tw_o == tw_model, "R7", "K=0 keeps results",
        64'(tw_o), 64'(tw_model));
    @(negedge clk);

    run_case(1, 5, 131072, 131072, 1'b0, "R4"); // window exactly 2^17 clocks
    run_case(3, 4, 10, 30, 1'b0, "R9");         // accepted start clears ovf

    chk(done_busy_err == 0, "R2", "busy low when done", 64'(done_busy_err), 64'd0);
    chk(done_long_err == 0, "R2", "done one cycle", 64'(done_long_err), 64'd0);
    summary();
  end

endmodule